// File: doc/BRIEF.md
# Fractional Master Clock Divider

This block derives an audio master clock from a faster source clock. A phase accumulator adds a step of (fraction + 1) every source cycle and wraps at a limit of (divide + 1). Each wrap flips a toggling output. The output frequency is therefore f_in * (fraction + 1) / (2 * (divide + 1)). Beside the toggling output, the block gives a one-cycle enable pulse on each rising output edge, for logic that stays in the source clock domain.

The ratio can be reprogrammed while the divider runs. A write strobe captures a new divide/fraction pair and raises a busy flag. The new pair takes effect at the next output edge, and the accumulator restarts from zero at that point. Writes that arrive while busy is high are dropped. When the output enable is low, the divider is held cleared and the source clock is passed straight through.

Top module: `mclk_frac_div`

## Requirements
- R1: After reset, with the output enable high, clk_o is 0, clk_en_o is 0 and busy_o is 0, and the active ratio is divide = 0, fraction = 0.
- R2: With the output enable high and a steady active ratio D/F (F <= D), any window of k*(D+1) consecutive cycles contains exactly k*(F+1) transitions of clk_o.
- R3: clk_en_o is high for exactly one cycle per rising edge of clk_o, namely the cycle in which clk_o has just risen, so it pulses half as often as clk_o changes.
- R4: When the fraction equals the divide value, clk_o changes on every source cycle.
- R5: A fraction larger than the divide value acts as if it were equal to the divide value.
- R6: A write strobe while busy_o is low captures div_i and frac_i and sets busy_o from the next cycle on. busy_o never rises without such a write.
- R7: A write strobe while busy_o is high is ignored, and the ratio captured first is the one that takes effect.
- R8: With the output enable high, a captured ratio takes effect on a clk_o transition, and busy_o falls one cycle after that transition. busy_o therefore stays high for at least two cycles.
- R9: With the output enable low, clk_o follows the source clock, clk_en_o is held at 1, the divider state is cleared, and a pending ratio is applied without waiting for an output edge. When the enable returns, clk_o starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 12 | Divide value; the wrap limit is div_i + 1 |
| frac_i | input | 8 | Fraction value; the accumulator step is frac_i + 1 |
| wr_i | input | 1 | Ratio write strobe, one per source cycle |
| oe_i | input | 1 | 1: divider drives the output; 0: source clock bypass |
| clk_o | output | 1 | Divided toggling clock, or the source clock in bypass |
| clk_en_o | output | 1 | One-cycle pulse on each rising clk_o edge; 1 in bypass |
| busy_o | output | 1 | Ratio update in progress |

## Verification
The assertions assume that oe_i and wr_i change only between source clock edges, and that the enable-pulse check is only meaningful after oe_i has been high for at least one full cycle. They also assume that frac_i fits within the divide width. The stimulus drives every input on the falling source edge and toggles oe_i only on cycle boundaries. It applies writes back to back to cover the busy window, and it sweeps ratios that include the equal case and the clamped case. A behavioural model is checked on every cycle. Exact window counts of output transitions check the ratio independently of the model.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;
  localparam int unsigned DIV_W_DEF  = 12;
  localparam int unsigned FRAC_W_DEF = 8;
endpackage

// File: rtl/mclk_ratio_ctl.sv
module mclk_ratio_ctl #(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              edge_i,
  input  logic              run_i,
  output logic [DIV_W-1:0]  act_div_o,
  output logic [FRAC_W-1:0] act_frac_o,
  output logic              apply_o,
  output logic              busy_o
);
  logic              busy_q, applied_q;
  logic [DIV_W-1:0]  pend_div_q, act_div_q;
  logic [FRAC_W-1:0] pend_frac_q, act_frac_q;
  logic              accept, apply;

  assign accept = wr_i & ~busy_q;
  // swap only on an output edge, or at once while the divider is held
  assign apply  = busy_q & ~applied_q & (edge_i | ~run_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      applied_q   <= 1'b0;
      pend_div_q  <= '0;
      pend_frac_q <= '0;
      act_div_q   <= '0;
      act_frac_q  <= '0;
    end else if (applied_q) begin
      busy_q    <= 1'b0;
      applied_q <= 1'b0;
    end else begin
      if (accept) begin
        busy_q      <= 1'b1;
        pend_div_q  <= div_i;
        pend_frac_q <= frac_i;
      end
      if (apply) begin
        act_div_q  <= pend_div_q;
        act_frac_q <= pend_frac_q;
        applied_q  <= 1'b1;
      end
    end
  end

  assign act_div_o  = act_div_q;
  assign act_frac_o = act_frac_q;
  assign apply_o    = apply;
  assign busy_o     = busy_q;
endmodule

// File: rtl/mclk_phase_acc.sv
module mclk_phase_acc #(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              restart_i,
  output logic              fire_o,
  output logic              tog_o,
  output logic              en_o
);
  localparam int unsigned ACC_W = DIV_W + 2;

  logic [ACC_W-1:0] acc_q, div_w, frac_w, step, lim, sum;
  logic             tog_q, en_q, fire;

  assign div_w  = ACC_W'(div_i);
  assign frac_w = ACC_W'(frac_i);
  // fraction clamped to divide keeps acc below lim
  assign step   = ((frac_w > div_w) ? div_w : frac_w) + ACC_W'(1);
  assign lim    = div_w + ACC_W'(1);
  assign sum    = acc_q + step;
  assign fire   = run_i & (sum >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      tog_q <= 1'b0;
      en_q  <= 1'b0;
    end else if (!run_i) begin
      acc_q <= '0;
      tog_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q <= fire & ~tog_q;
      if (fire) tog_q <= ~tog_q;
      if (restart_i)  acc_q <= '0;
      else if (fire)  acc_q <= sum - lim;
      else            acc_q <= sum;
    end
  end

  assign fire_o = fire;
  assign tog_o  = tog_q;
  assign en_o   = en_q;
endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div
  import mclk_div_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              wr_i,
  input  logic              oe_i,
  output logic              clk_o,
  output logic              clk_en_o,
  output logic              busy_o
);
  logic [DIV_W-1:0]  act_div;
  logic [FRAC_W-1:0] act_frac;
  logic              apply, fire, tog, en;

  mclk_ratio_ctl #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .div_i      (div_i),
    .frac_i     (frac_i),
    .edge_i     (fire),
    .run_i      (oe_i),
    .act_div_o  (act_div),
    .act_frac_o (act_frac),
    .apply_o    (apply),
    .busy_o     (busy_o)
  );

  mclk_phase_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (oe_i),
    .div_i     (act_div),
    .frac_i    (act_frac),
    .restart_i (apply),
    .fire_o    (fire),
    .tog_o     (tog),
    .en_o      (en)
  );

  // bypass select
  assign clk_o    = oe_i ? tog : clk_i;
  assign clk_en_o = oe_i ? en  : 1'b1;
endmodule

// File: rtl/mclk_frac_div_chk.sv
module mclk_frac_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic oe_i,
  input logic clk_o,
  input logic clk_en_o,
  input logic busy_o
);
  p_en_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && $past(oe_i) && clk_en_o) |-> (clk_o && !$past(clk_o)));

  p_busy_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o);

  p_busy_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !busy_o) |=> !busy_o);

  p_busy_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(busy_o, 2));

  p_bypass_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> clk_en_o);
endmodule

bind mclk_frac_div mclk_frac_div_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .oe_i     (oe_i),
  .clk_o    (clk_o),
  .clk_en_o (clk_en_o),
  .busy_o   (busy_o)
);

// File: tb/mclk_frac_div_bench.sv
module mclk_frac_div_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div = '0;
  logic [7:0]  frac = '0;
  logic        wr = 1'b0;
  logic        oe = 1'b1;
  logic        clk_o, clk_en_o, busy_o;

  int n_chk = 0, n_bad = 0;
  int m_acc = 0, m_tog = 0, m_en = 0, m_busy = 0, m_app = 0;
  int m_pd = 0, m_pf = 0, m_ad = 0, m_af = 0;
  int h0 = 0, h1 = 0, h2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclk_frac_div u_mclk_frac_div (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .frac_i(frac),
    .wr_i(wr), .oe_i(oe), .clk_o(clk_o), .clk_en_o(clk_en_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int lim, st, sum;
    bit fire, apply, accept;
    lim = m_ad + 1;
    st  = ((m_af > m_ad) ? m_ad : m_af) + 1;
    sum = m_acc + st;
    fire   = oe && (sum >= lim);
    apply  = (m_busy != 0) && (m_app == 0) && (fire || !oe);
    accept = wr && (m_busy == 0);
    if (m_app != 0) begin
      m_busy = 0; m_app = 0;
    end else begin
      if (accept) begin m_busy = 1; m_pd = int'(div); m_pf = int'(frac); end
      if (apply)  begin m_ad = m_pd; m_af = m_pf; m_app = 1; end
    end
    if (!oe) begin
      m_acc = 0; m_tog = 0; m_en = 0;
    end else begin
      m_en  = (fire && m_tog == 0) ? 1 : 0;
      m_acc = apply ? 0 : (fire ? sum - lim : sum);
      if (fire) m_tog = 1 - m_tog;
    end
  endtask

  // one source cycle: model at the rising edge, compare at the falling edge
  task automatic tick();
    int e_clk, e_en;
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    e_clk = oe ? m_tog : 0;
    e_en  = oe ? m_en : 1;
    chk(clk_o == e_clk[0],    "R2 model clk_o",    int'(clk_o),    e_clk);
    chk(clk_en_o == e_en[0],  "R3 model clk_en_o", int'(clk_en_o), e_en);
    chk(busy_o == m_busy[0],  "R6 model busy_o",   int'(busy_o),   m_busy);
    h2 = h1; h1 = h0; h0 = int'(clk_o);
  endtask

  task automatic wait_idle(input string req);
    int guard = 0;
    while (busy_o && guard < 5000) begin tick(); guard++; end
    chk(!busy_o, req, int'(busy_o), 0);
  endtask

  task automatic set_ratio(input int d, input int f);
    div = 12'(d); frac = 8'(f); wr = 1'b1;
    tick();
    wr = 1'b0;
    chk(busy_o, "R6 busy after write", int'(busy_o), 1);
    wait_idle("R8 busy clears");
  endtask

  task automatic count(input int n, output int tg, output int ep);
    int prev = int'(clk_o);
    tg = 0; ep = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (int'(clk_o) != prev) tg++;
      if (clk_en_o) ep++;
      prev = int'(clk_o);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int tg, ep;
    repeat (3) @(negedge clk);
    chk(clk_o == 1'b0 && clk_en_o == 1'b0 && busy_o == 1'b0, "R1 reset outputs",
        int'({clk_o, clk_en_o, busy_o}), 0);
    rst_n = 1'b1;
    // R1: reset ratio 0/0 toggles every cycle
    count(8, tg, ep);
    chk(tg == 8, "R1 default ratio toggles", tg, 8);

    // R2/R3: D=3 F=0
    set_ratio(3, 0);
    count(40, tg, ep);
    chk(tg == 10, "R2 toggles D3 F0", tg, 10);
    chk(ep == 5,  "R3 enable pulses D3 F0", ep, 5);

    // R7: second write inside the busy window is dropped
    div = 12'd4; frac = 8'd1; wr = 1'b1;
    tick();
    div = 12'd0; frac = 8'd0;
    tick();
    wr = 1'b0;
    wait_idle("R8 busy clears after R7 writes");
    chk(h2 != h1, "R8 apply on clk_o edge", h1, 1 - h2);
    count(50, tg, ep);
    chk(tg == 20, "R7 first ratio kept", tg, 20);
    chk(ep == 10, "R3 enable pulses D4 F1", ep, 10);

    // R2: larger divide, fractional ratio
    set_ratio(9, 2);
    count(100, tg, ep);
    chk(tg == 30, "R2 toggles D9 F2", tg, 30);

    // R4: fraction equals divide
    set_ratio(5, 5);
    count(30, tg, ep);
    chk(tg == 30, "R4 toggle every cycle", tg, 30);
    chk(ep == 15, "R3 enable pulses fast", ep, 15);

    // R5: fraction above divide clamps
    set_ratio(2, 9);
    count(30, tg, ep);
    chk(tg == 30, "R5 clamped fraction", tg, 30);

    // R9: bypass
    set_ratio(3, 0);
    oe = 1'b0;
    tick();
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(clk_en_o == 1'b1, "R9 bypass enable", int'(clk_en_o), 1);
      chk(clk_o == 1'b0, "R9 bypass low phase", int'(clk_o), 0);
      @(posedge clk); #(CLK_PERIOD/4);
      chk(clk_o == 1'b1, "R9 bypass high phase", int'(clk_o), 1);
      @(negedge clk);
      model_step();
      h2 = h1; h1 = h0; h0 = int'(clk_o);
    end
    div = 12'd1; frac = 8'd0; wr = 1'b1;
    tick();
    wr = 1'b0;
    tick();
    tick();
    chk(!busy_o, "R9 immediate apply in bypass", int'(busy_o), 0);
    oe = 1'b1;
    tick();
    count(40, tg, ep);
    chk(tg == 20, "R9 ratio applied during bypass", tg, 20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule